// File: doc/BRIEF.md
# Pixel Thresholding Unit

This block processes a stream of pixels one at a time. Each pixel comes in with a valid qualifier and is compared against a programmable level. One output policy is chosen by a one-bit mode input. In binary mode every pixel becomes either full black (zero) or full white (all ones), which suits halftone-style rendering. In pass mode, a pixel above the level leaves unchanged and any other pixel is forced to zero, which suits cleaning up an edge-strength map.

The level and the mode live in a small configuration register. A write to it is taken only when the pipeline is empty, meaning no input pixel is offered and no result is being presented. This keeps every result consistent with a single setting. Each result appears exactly one clock after its pixel, from a registered output stage.

Top module: `pixel_threshold_unit`

## Requirements
- R1: While `rst` is high, `out_valid` is 0 in the following cycle. After reset the level is 2^(PIX_W-1)-1 (127 for 8-bit pixels) and the mode is binary (`cfg_mode` = 0).
- R2: `out_valid` is high in the cycle after a cycle with `pix_valid` high, and low in the cycle after a cycle with `pix_valid` low.
- R3: In binary mode (`cfg_mode` = 0), the result is all ones when the pixel is strictly greater than the level, and 0 otherwise.
- R4: In pass mode (`cfg_mode` = 1), the result equals the input pixel when the pixel is strictly greater than the level, and 0 otherwise.
- R5: A pixel equal to the level gives a result of 0 in both modes.
- R6: `out_data` is 0 in every cycle in which `out_valid` is low.
- R7: A `cfg_we` pulse in a cycle with `pix_valid` low and `out_valid` low loads `cfg_level` and `cfg_mode`. The new setting applies to a pixel offered in the very next cycle.
- R8: A `cfg_we` pulse in a cycle with `pix_valid` high or `out_valid` high is dropped, and later pixels keep being judged with the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_level | input | PIX_W | New threshold level |
| cfg_mode | input | 1 | New mode: 0 binary, 1 pass |
| pix_valid | input | 1 | Input pixel qualifier |
| pix_data | input | PIX_W | Input pixel value |
| out_valid | output | 1 | Result qualifier |
| out_data | output | PIX_W | Result pixel value |

## Verification
The bench builds the unit with PIX_W = 4. This shrinks the value space to 16 levels and 16 pixels, so every level is swept against every pixel in both modes. That sweep covers every equality point and both extremes of the range, including a level of all ones, where nothing can pass. Back-to-back streaming also exercises configuration writes that collide with a pixel that is being offered or that is still in the output stage. It checks that those writes are dropped and that an idle write takes effect on the next pixel.

// File: rtl/thr_pkg.sv
package thr_pkg;
  typedef enum logic {
    MODE_BINARY = 1'b0,
    MODE_PASS   = 1'b1
  } thr_mode_e;
endpackage

// File: rtl/thr_cfg_regs.sv
module thr_cfg_regs
  import thr_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [PIX_W-1:0] wr_level,
  input  logic             wr_mode,
  input  logic             busy,
  output logic [PIX_W-1:0] level_q,
  output thr_mode_e        mode_q
);
  localparam logic [PIX_W-1:0] RST_LEVEL = {1'b0, {(PIX_W-1){1'b1}}};

  // Writes only land while nothing is in flight
  logic accept;
  assign accept = wr_en && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= RST_LEVEL;
      mode_q  <= MODE_BINARY;
    end else if (accept) begin
      level_q <= wr_level;
      mode_q  <= thr_mode_e'(wr_mode);
    end
  end
endmodule

// File: rtl/thr_decide.sv
module thr_decide
  import thr_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] pixel,
  input  logic [PIX_W-1:0] level,
  input  thr_mode_e        mode,
  output logic [PIX_W-1:0] result
);
  localparam logic [PIX_W-1:0] WHITE = {PIX_W{1'b1}};

  // A single strict comparator feeds both output policies
  logic above;
  assign above = pixel > level;

  logic [PIX_W-1:0] policy [2];
  assign policy[0] = above ? WHITE : '0;
  assign policy[1] = above ? pixel : '0;

  always_comb begin
    unique case (mode)
      MODE_BINARY: result = policy[0];
      MODE_PASS:   result = policy[1];
      default:     result = '0;
    endcase
  end
endmodule

// File: rtl/thr_out_stage.sv
module thr_out_stage #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_data,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_data  <= in_valid ? in_data : '0;
    end
  end
endmodule

// File: rtl/pixel_threshold_unit.sv
module pixel_threshold_unit
  import thr_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [PIX_W-1:0] cfg_level,
  input  logic             cfg_mode,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_data
);
  logic [PIX_W-1:0] level_q;
  thr_mode_e        mode_q;
  logic [PIX_W-1:0] decided;
  logic             in_flight;

  assign in_flight = pix_valid || out_valid;

  thr_cfg_regs #(.PIX_W(PIX_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_we),
    .wr_level (cfg_level),
    .wr_mode  (cfg_mode),
    .busy     (in_flight),
    .level_q  (level_q),
    .mode_q   (mode_q)
  );

  thr_decide #(.PIX_W(PIX_W)) u_dec (
    .pixel  (pix_data),
    .level  (level_q),
    .mode   (mode_q),
    .result (decided)
  );

  thr_out_stage #(.PIX_W(PIX_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (pix_valid),
    .in_data   (decided),
    .out_valid (out_valid),
    .out_data  (out_data)
  );
endmodule

// File: rtl/thr_chk.sv
module thr_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic             pix_valid,
  input logic [PIX_W-1:0] pix_data,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_data,
  input logic [PIX_W-1:0] level,
  input logic             mode
);
  localparam logic [PIX_W-1:0] RST_LEVEL = {1'b0, {(PIX_W-1){1'b1}}};
  localparam logic [PIX_W-1:0] WHITE     = {PIX_W{1'b1}};

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && level == RST_LEVEL && mode == 1'b0));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> out_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> !out_valid);

  // R3
  binary_level_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && mode == 1'b0) |=>
      (out_data == (($past(pix_data) > $past(level)) ? WHITE : '0)));

  // R4
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && mode == 1'b1 && pix_data > level) |=> (out_data == $past(pix_data)));

  // R5
  equal_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && pix_data == level) |=> (out_data == '0));

  // R6
  idle_data_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_data == '0));

  // R8
  busy_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && (pix_valid || out_valid)) |=> ($stable(level) && $stable(mode)));
endmodule

bind pixel_threshold_unit thr_chk #(.PIX_W(PIX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .pix_valid (pix_valid),
  .pix_data  (pix_data),
  .out_valid (out_valid),
  .out_data  (out_data),
  .level     (level_q),
  .mode      (mode_q)
);

// File: tb/sim_pixel_threshold_unit.sv
`timescale 1ns/1ps
module sim_pixel_threshold_unit;
  localparam int W    = 4;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_we = 1'b0;
  logic [W-1:0] cfg_level = '0;
  logic         cfg_mode = 1'b0;
  logic         pix_valid = 1'b0;
  logic [W-1:0] pix_data = '0;
  logic         out_valid;
  logic [W-1:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pixel_threshold_unit #(.PIX_W(W)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_level(cfg_level),
    .cfg_mode(cfg_mode), .pix_valid(pix_valid), .pix_data(pix_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic int expect_of(int p, int t, int m);
    if (p <= t) return 0;
    return (m == 0) ? MAXV : p;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(int t, int m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_level = W'(t); cfg_mode = m[0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Offer one pixel, then check its result one cycle later
  task automatic one_pixel(string req, int p, int exp);
    pix_valid = 1'b1; pix_data = W'(p);
    @(negedge clk);
    pix_valid = 1'b0;
    check({req, " valid"}, int'(out_valid), 1);
    check(req, int'(out_data), exp);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", int'(out_valid), 0);
    check("R6 out_data in reset", int'(out_data), 0);
    rst = 1'b0;
    @(negedge clk);
    // R1 defaults: level 7, binary mode
    one_pixel("R1 default level at 7", 7, 0);
    one_pixel("R1 default level at 8", 8, MAXV);
    check("R2 valid drops", int'(out_valid), 0);
    check("R6 idle data zero", int'(out_data), 0);

    // R3 R4 R5: full sweep, pixels streamed back to back
    for (int m = 0; m < 2; m++) begin
      for (int t = 0; t <= MAXV; t++) begin
        write_cfg(t, m);
        for (int p = 0; p <= MAXV + 1; p++) begin
          if (p > 0) begin
            check("R2 streaming valid", int'(out_valid), 1);
            if (p - 1 == t)
              check("R5 equal gives zero", int'(out_data), 0);
            else if (m == 0)
              check("R3 binary sweep", int'(out_data), expect_of(p - 1, t, m));
            else
              check("R4 pass sweep", int'(out_data), expect_of(p - 1, t, m));
          end
          if (p <= MAXV) begin
            pix_valid = 1'b1; pix_data = W'(p);
          end else begin
            pix_valid = 1'b0;
          end
          @(negedge clk);
        end
        check("R2 valid after stream", int'(out_valid), 0);
      end
    end

    // R7: idle write applies to the pixel in the very next cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_level = 4'd3; cfg_mode = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    one_pixel("R7 next-cycle pixel", 9, 9);
    one_pixel("R7 new level used", 3, 0);

    // R8: write while a pixel is offered is dropped
    pix_valid = 1'b1; pix_data = 4'd5;
    cfg_we = 1'b1; cfg_level = 4'd12; cfg_mode = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; pix_valid = 1'b0;
    check("R8 collided pixel", int'(out_data), 5);
    // R8: write while a result is presented is dropped
    cfg_we = 1'b1; cfg_level = 4'd12; cfg_mode = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0;
    one_pixel("R8 old setting kept", 10, 10);
    one_pixel("R8 old level kept", 4, 4);

    // R1: reset restores defaults
    rst = 1'b1;
    @(negedge clk);
    check("R1 valid cleared by reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    one_pixel("R1 reset restores binary", 9, MAXV);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 50000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule